// File: doc/BRIEF.md
# Segment Translation and Protection Unit

The unit turns a virtual address into a physical address using a per-segment table. The upper bits of the virtual address choose one of the table entries. The lower bits are an offset into that segment. Each entry holds a physical base, a segment size and a two-bit permission code. Every request also carries an access kind: read, write or execute. The unit checks the offset against the size and checks the access kind against the permission code. One cycle after the request it returns either the base plus the offset, or a fault whose cause code says which check failed.

Software fills the table through a one-entry-per-cycle write port. A combinational save port reads out any entry. Together these two ports let a context switch store the whole table and later write it back unchanged. After reset every entry is empty, so every access faults until software loads the table.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every table entry reads back as base 0, size 0 and permission 00. `rsp_valid`, `rsp_fault`, `rsp_cause` and `rsp_paddr` are all 0.
- R2: Bits [31:28] of `req_vaddr` select the table entry. Bits [27:0] are the offset within the segment.
- R3: When `tbl_wr_en` is high at a rising edge, the addressed entry takes `tbl_wr_base`, `tbl_wr_size` and `tbl_wr_perm`, and no other entry changes. From then on the save port returns those values combinationally for `sv_idx`.
- R4: `rsp_valid` is high in exactly the cycle that follows a cycle with `req_valid` high, and low otherwise.
- R5: A request that passes both checks returns `rsp_fault` = 0 and `rsp_cause` = 2'b00. It also returns `rsp_paddr` = base + offset, taken modulo 2^32.
- R6: An offset greater than or equal to the segment size is a bound violation. It gives `rsp_fault` = 1 with `rsp_cause` = 2'b01, so a size of 0 blocks the whole segment.
- R7: Permission codes are: 00 none; 01 read only; 10 read and write; 11 read and execute. Access kinds are: 00 read; 01 write; 10 execute; 11 reserved, which no code allows. An access that the code does not allow gives `rsp_fault` = 1 with `rsp_cause` = 2'b10.
- R8: When both the bound check and the permission check fail, `rsp_cause` is 2'b01.
- R9: `rsp_paddr` is 0 on a faulted response. All response outputs are 0 in a cycle without a response.
- R10: A request and a table write to the same entry in the same cycle: the request is checked against the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_wr_en | input | 1 | Write one table entry |
| tbl_wr_idx | input | 4 | Entry to write |
| tbl_wr_base | input | 32 | Physical base to store |
| tbl_wr_size | input | 28 | Segment size to store |
| tbl_wr_perm | input | 2 | Permission code to store |
| sv_idx | input | 4 | Entry shown on the save port |
| sv_base | output | 32 | Stored base of entry `sv_idx` |
| sv_size | output | 28 | Stored size of entry `sv_idx` |
| sv_perm | output | 2 | Stored permission of entry `sv_idx` |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Virtual address: segment index and offset |
| req_kind | input | 2 | Access kind |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Request was refused |
| rsp_cause | output | 2 | Fault cause code |

## Verification
A translation result appears one rising edge after its request. A table write shows on the save port right after the edge that takes it. The bench drives every input just after a falling edge. It then checks the response at the next falling edge, which comes after exactly one capturing edge. It compares the response with a result worked out from the bench's own copy of the table as it stood before that cycle's write. Save-port reads are sampled a short delay after the index changes, with no edge between.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        PERM_NONE  = 2'b00,
        PERM_READ  = 2'b01,
        PERM_WRITE = 2'b10,
        PERM_EXEC  = 2'b11
    } perm_t;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_EXEC  = 2'b10,
        KIND_RSVD  = 2'b11
    } kind_t;

    typedef enum logic [1:0] {
        CAUSE_OK    = 2'b00,
        CAUSE_BOUND = 2'b01,
        CAUSE_PERM  = 2'b10
    } cause_t;

    // R7: which access kinds each code admits
    function automatic logic perm_allows(perm_t p, kind_t k);
        logic ok;
        case (k)
            KIND_READ:  ok = (p != PERM_NONE);
            KIND_WRITE: ok = (p == PERM_WRITE);
            KIND_EXEC:  ok = (p == PERM_EXEC);
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int BASE_W = 32,
    parameter int SIZE_W = 28,
    localparam int N_SEG = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BASE_W-1:0] wr_base,
    input  logic [SIZE_W-1:0] wr_size,
    input  perm_t             wr_perm,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [BASE_W-1:0] lk_base,
    output logic [SIZE_W-1:0] lk_size,
    output perm_t             lk_perm,
    input  logic [IDX_W-1:0]  sv_idx,
    output logic [BASE_W-1:0] sv_base,
    output logic [SIZE_W-1:0] sv_size,
    output perm_t             sv_perm
);

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
        perm_t             perm;
    } entry_t;

    entry_t ent [N_SEG];

    for (genvar g = 0; g < N_SEG; g++) begin : g_ent
        entry_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_d.base = wr_base;
                ent_d.size = wr_size;
                ent_d.perm = wr_perm;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ent[g] = ent_q;
    end

    always_comb begin
        lk_base = ent[lk_idx].base;
        lk_size = ent[lk_idx].size;
        lk_perm = ent[lk_idx].perm;
        sv_base = ent[sv_idx].base;
        sv_size = ent[sv_idx].size;
        sv_perm = ent[sv_idx].perm;
    end

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W  = 28,
    parameter int BASE_W = 32
) (
    input  logic [OFF_W-1:0]  offset,
    input  kind_t             kind,
    input  logic [BASE_W-1:0] base,
    input  logic [OFF_W-1:0]  size,
    input  perm_t             perm,
    output logic              fault,
    output cause_t            cause,
    output logic [BASE_W-1:0] paddr
);

    logic bound_bad;
    logic perm_bad;

    always_comb begin
        bound_bad = (offset >= size);
        perm_bad  = !perm_allows(perm, kind);
        fault     = bound_bad || perm_bad;
        // bound violation outranks permission violation
        if (bound_bad)     cause = CAUSE_BOUND;
        else if (perm_bad) cause = CAUSE_PERM;
        else               cause = CAUSE_OK;
        paddr = fault ? '0 : (base + BASE_W'(offset));
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int IDX_W = 4,
    parameter int PA_W  = 32,
    localparam int OFF_W = VA_W - IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbl_wr_en,
    input  logic [IDX_W-1:0] tbl_wr_idx,
    input  logic [PA_W-1:0]  tbl_wr_base,
    input  logic [OFF_W-1:0] tbl_wr_size,
    input  logic [1:0]       tbl_wr_perm,
    input  logic [IDX_W-1:0] sv_idx,
    output logic [PA_W-1:0]  sv_base,
    output logic [OFF_W-1:0] sv_size,
    output logic [1:0]       sv_perm,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault,
    output logic [1:0]       rsp_cause
);

    typedef struct packed {
        logic            valid;
        logic            fault;
        cause_t          cause;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic [IDX_W-1:0] seg_idx;
    logic [OFF_W-1:0] seg_off;
    logic [PA_W-1:0]  lk_base;
    logic [OFF_W-1:0] lk_size;
    perm_t            lk_perm;
    perm_t            sv_perm_e;
    logic             chk_fault;
    cause_t           chk_cause;
    logic [PA_W-1:0]  chk_paddr;

    assign seg_idx = req_vaddr[VA_W-1 -: IDX_W];
    assign seg_off = req_vaddr[OFF_W-1:0];

    seg_table #(
        .IDX_W (IDX_W),
        .BASE_W(PA_W),
        .SIZE_W(OFF_W)
    ) i_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr_en),
        .wr_idx (tbl_wr_idx),
        .wr_base(tbl_wr_base),
        .wr_size(tbl_wr_size),
        .wr_perm(perm_t'(tbl_wr_perm)),
        .lk_idx (seg_idx),
        .lk_base(lk_base),
        .lk_size(lk_size),
        .lk_perm(lk_perm),
        .sv_idx (sv_idx),
        .sv_base(sv_base),
        .sv_size(sv_size),
        .sv_perm(sv_perm_e)
    );

    assign sv_perm = sv_perm_e;

    seg_check #(
        .OFF_W (OFF_W),
        .BASE_W(PA_W)
    ) i_check (
        .offset(seg_off),
        .kind  (kind_t'(req_kind)),
        .base  (lk_base),
        .size  (lk_size),
        .perm  (lk_perm),
        .fault (chk_fault),
        .cause (chk_cause),
        .paddr (chk_paddr)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = chk_fault;
            rsp_d.cause = chk_cause;
            rsp_d.paddr = chk_paddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_cause = rsp_q.cause;
    assign rsp_paddr = rsp_q.paddr;

endmodule

// File: rtl/seg_xlate_checker.sv
module seg_xlate_checker #(
    parameter int VA_W = 32,
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_kind,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic [1:0]      rsp_cause
);

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R4

    AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R4

    AST_OK_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_cause == 2'b00)); // R5

    AST_FAULT_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_cause == 2'b01 || rsp_cause == 2'b10)); // R6

    AST_RSVD_KIND_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'b11) |=> rsp_fault); // R7

    AST_FAULT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_paddr == '0)); // R9

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_fault && rsp_cause == 2'b00 && rsp_paddr == '0)); // R9

endmodule

bind seg_xlate_unit seg_xlate_checker #(
    .VA_W(VA_W),
    .PA_W(PA_W)
) i_seg_xlate_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_kind (req_kind),
    .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause)
);

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [3:0]  tbl_wr_idx = '0;
    logic [31:0] tbl_wr_base = '0;
    logic [27:0] tbl_wr_size = '0;
    logic [1:0]  tbl_wr_perm = '0;
    logic [3:0]  sv_idx = '0;
    logic [31:0] sv_base;
    logic [27:0] sv_size;
    logic [1:0]  sv_perm;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_base [16];
    logic [27:0] m_size [16];
    logic [1:0]  m_perm [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    seg_xlate_unit i_seg_xlate_unit (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_base(tbl_wr_base),
        .tbl_wr_size(tbl_wr_size), .tbl_wr_perm(tbl_wr_perm),
        .sv_idx(sv_idx), .sv_base(sv_base), .sv_size(sv_size), .sv_perm(sv_perm),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .rsp_cause(rsp_cause)
    );

    // R7 rule table, from the requirement text
    function automatic logic allowed(logic [1:0] perm, logic [1:0] kind);
        if (kind == 2'b00) return perm != 2'b00;
        if (kind == 2'b01) return perm == 2'b10;
        if (kind == 2'b10) return perm == 2'b11;
        return 1'b0;
    endfunction

    // expected {valid, fault, cause, paddr}
    function automatic logic [35:0] expect_rsp(logic rv, logic [31:0] va, logic [1:0] kind);
        logic [3:0]  idx;
        logic [27:0] off;
        if (!rv) return '0;
        idx = va[31:28];
        off = va[27:0];
        if (off >= m_size[idx]) return {1'b1, 1'b1, 2'b01, 32'h0};
        if (!allowed(m_perm[idx], kind)) return {1'b1, 1'b1, 2'b10, 32'h0};
        return {1'b1, 1'b0, 2'b00, m_base[idx] + {4'h0, off}};
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; checks the response one falling edge later.
    task automatic step(logic we, logic [3:0] widx, logic [31:0] wbase, logic [27:0] wsize,
                        logic [1:0] wperm, logic rv, logic [31:0] va, logic [1:0] kind,
                        string tag);
        logic [35:0] exp;
        tbl_wr_en = we; tbl_wr_idx = widx; tbl_wr_base = wbase;
        tbl_wr_size = wsize; tbl_wr_perm = wperm;
        req_valid = rv; req_vaddr = va; req_kind = kind;
        exp = expect_rsp(rv, va, kind);
        if (we) begin
            m_base[widx] = wbase; m_size[widx] = wsize; m_perm[widx] = wperm;
        end
        @(negedge clk);
        tbl_wr_en = 1'b0; req_valid = 1'b0;
        check(tag, {28'h0, rsp_valid, rsp_fault, rsp_cause, rsp_paddr}, {28'h0, exp});
    endtask

    task automatic load(logic [3:0] idx, logic [31:0] b, logic [27:0] s, logic [1:0] p);
        step(1'b1, idx, b, s, p, 1'b0, 32'h0, 2'b00, "R3 load idle");
    endtask

    task automatic save_check(logic [3:0] idx, string tag);
        sv_idx = idx;
        #1;
        check(tag, {2'h0, sv_base, sv_size, sv_perm}, {2'h0, m_base[idx], m_size[idx], m_perm[idx]});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        void'($urandom(32'h5E6A_11C3));
        for (int i = 0; i < 16; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_perm[i] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: outputs and table after reset
        check("R1 rsp after reset", {60'h0, rsp_valid, rsp_fault, rsp_cause}, 64'h0);
        check("R1 paddr after reset", {32'h0, rsp_paddr}, 64'h0);
        save_check(4'd5, "R1 save entry 5 empty");
        rst_n = 1'b1;
        @(negedge clk);
        // R1 R6: empty entry blocks everything
        step(1'b0, 0, 0, 0, 0, 1'b1, 32'h3000_0000, 2'b00, "R1 R6 empty segment faults");

        // R3 R5 R2: read access in bound
        load(4'd2, 32'h4000_0000, 28'h100, 2'b01);
        save_check(4'd2, "R3 save entry 2");
        save_check(4'd3, "R3 other entry untouched");
        step(1'b0, 0, 0, 0, 0, 1'b1, 32'h2000_00FF, 2'b00, "R5 R2 last byte in bound");
        step(1'b0, 0, 0, 0, 0, 1'b1, 32'h2000_0100, 2'b00, "R6 offset equal to size");
        step(1'b0, 0, 0, 0, 0, 1'b1, 32'h2000_0010, 2'b01, "R7 write to read-only");
        step(1'b0, 0, 0, 0, 0, 1'b1, 32'h2000_0200, 2'b01, "R8 both fail gives bound");
        step(1'b0, 0, 0, 0, 0, 1'b1, 32'h2000_0010, 2'b11, "R7 reserved kind");

        // R5: wrap around the top of physical space
        load(4'd15, 32'hFFFF_FFF0, 28'hFFF_FFFF, 2'b11);
        step(1'b0, 0, 0, 0, 0, 1'b1, 32'hF000_0020, 2'b10, "R5 wrapped sum");
        step(1'b0, 0, 0, 0, 0, 1'b1, 32'hF000_0020, 2'b01, "R7 write to exec segment");

        // R9 R4: idle cycle
        step(1'b0, 0, 0, 0, 0, 1'b0, 32'hF000_0020, 2'b10, "R4 R9 no request no response");

        // R10: write and request to the same entry in one cycle
        step(1'b1, 4'd7, 32'h0000_1000, 28'hFFF_FFFF, 2'b10, 1'b1, 32'h7000_0004, 2'b01,
             "R10 request sees old entry");
        step(1'b0, 0, 0, 0, 0, 1'b1, 32'h7000_0004, 2'b01, "R10 next request sees new entry");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic we, rv;
            logic [27:0] sz;
            r  = $urandom;
            we = (r[2:0] == 3'd0);
            rv = (r[4:3] != 2'd0);
            sz = (r[7:5] == 3'd0) ? 28'h0 : 28'($urandom);
            step(we, 4'($urandom), $urandom, sz, 2'($urandom), rv, $urandom, 2'($urandom),
                 "R5 R6 R7 R8 random");
        end
        for (int i = 0; i < 16; i++) save_check(4'(i), "R3 save after random");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule